// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits on the host side of a parallel byte-wide EEPROM and carries out page writes. A request gives a 13-bit start address and a byte count. The bytes then arrive one at a time on a valid/ready stream. For every byte the controller drives the address and data bus, lowers chip-enable, and pulses write-enable low for a fixed number of cycles. Bus values are held steady for programmable setup and hold windows around the pulse. Output-enable stays high the whole time.

The device latches bytes only while write-enable pulses keep coming inside its maximum byte-load interval. The controller therefore paces its pulses against that limit. If the stream stalls too long, it closes the page early and reports a short page.

When a page is complete, write-enable is kept high long enough for the device to start programming. The controller then follows the open-drain ready/busy pin: first low, then high again. It does not wait a fixed time. A request that runs past the end of a 32-byte page continues on the next page once the device is ready again. A watchdog limits how long the busy phase may last.

Top module: `eeprom_pgwr_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken when `req_valid` and `req_ready` are both high. `req_cnt` holds the byte count minus one, so values 0..31 mean 1..32 bytes.
- R2: Byte k of a request (k from 0) goes to address `req_addr + k`. Bits 12..5 stay constant within one page, and bits 4..0 select the byte in that page.
- R3: Before each write-enable falling edge, chip-enable is low and address and data are stable for at least SETUP_CYC cycles. Write-enable stays low for exactly PULSE_CYC cycles. Chip-enable, address and data stay unchanged for HOLD_CYC cycles from the rising edge on, with the rising cycle counted. Write-enable is never low while chip-enable is high, and `mem_oe_n` is always high.
- R4: Within one page, write-enable is high for at most BLC_CYC cycles between a rising edge and the next falling edge.
- R5: After the last byte of a page, write-enable stays high for at least BLC_CYC cycles. The controller then waits for `mem_rdy` (1 = ready) to go low and then return high before it goes on.
- R6: The next byte of a page may be taken as late as the last cycle that still meets R4. If no byte is offered by then, the page is closed, unsent bytes are not consumed, and `done_short` is reported with `done`. The first byte of each page has no deadline.
- R7: When a request crosses a 32-byte boundary, the remaining bytes are written to the next page starting at offset 0. No write-enable falling edge occurs while `mem_rdy` is low.
- R8: If the busy phase lasts WD_CYC cycles without completing, the request ends with `done` and `done_timeout`.
- R9: After reset, the strobes are high and `done` is low. `done` is a single-cycle pulse, and `done_short`/`done_timeout` are meaningful only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted |
| req_addr | input | 13 | Start byte address |
| req_cnt | input | 5 | Byte count minus one |
| dat_valid | input | 1 | Stream byte offered |
| dat_ready | output | 1 | Controller takes the byte |
| dat_byte | input | 8 | Stream byte |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_oe_n | output | 1 | Output-enable, held high |
| mem_addr | output | 13 | Device address bus |
| mem_dq_o | output | 8 | Device data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_rdy | input | 1 | Ready/busy pin, 1 = ready |
| done | output | 1 | Request finished (pulse) |
| done_short | output | 1 | Page closed early by a stall |
| done_timeout | output | 1 | Busy phase exceeded the limit |

## Verification
Two things can land in the same cycle: a stream byte arriving and the byte-load deadline expiring. The bench offers the next byte after a chosen number of waiting cycles. With a delay of 7 the byte arrives exactly in the last legal cycle. It must be taken, and the measured high time must equal BLC_CYC with no short flag. With a delay of 8 the byte arrives one cycle late. The page must close with `done_short`, and only the earlier bytes must reach the device.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    localparam int ADDR_W = 13;
    localparam int OFF_W  = 5;
    localparam int DATA_W = 8;
    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_SETUP,
        S_LOW,
        S_HOLD,
        S_DRAIN,
        S_BSY_LO,
        S_BSY_HI
    } ctl_state_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } waddr_t;

    typedef struct packed {
        logic short_page;
        logic timeout;
    } stat_t;

    function automatic logic at_page_end(input logic [OFF_W-1:0] off);
        return &off;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/eepw_pace.sv
module eepw_pace #(
    parameter int BLC_CYC   = 12,
    parameter int SETUP_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic late,
    output logic drained
);
    localparam int LATEST = BLC_CYC - SETUP_CYC - 1;
    localparam int C_W    = $clog2(BLC_CYC + 1);

    logic [C_W-1:0] cnt;

    // Counts write-enable-high cycles since the last rising edge, minus one.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && cnt != C_W'(BLC_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign late    = (cnt >= C_W'(LATEST));
    assign drained = (cnt >= C_W'(BLC_CYC - 1));
endmodule

// File: rtl/eepw_wdog.sv
module eepw_wdog #(
    parameter int WD_CYC = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int C_W = $clog2(WD_CYC + 1);

    logic [C_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && cnt != C_W'(WD_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == C_W'(WD_CYC));
endmodule

// File: rtl/eeprom_pgwr_ctrl.sv
module eeprom_pgwr_ctrl
    import eepw_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2,
    parameter int BLC_CYC   = 12,
    parameter int WD_CYC    = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OFF_W-1:0]  req_cnt,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat_byte,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic              mem_rdy,
    output logic              done,
    output logic              done_short,
    output logic              done_timeout
);
    localparam int TMAX = max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
    localparam int T_W  = (TMAX > 1) ? $clog2(TMAX + 1) : 1;
    localparam int H_W  = $clog2(BLC_CYC + 2);

    ctl_state_t        st;
    waddr_t            wa;
    logic [OFF_W-1:0]  left;
    logic [DATA_W-1:0] byte_q;
    logic [T_W-1:0]    tmr;
    logic              first, fin, done_q;
    stat_t             stat_q;
    logic [1:0]        rdy_sync;
    logic              rdy_s, late, drained, expired;

    // Ready/busy is an asynchronous pin: two-flop synchronizer.
    always_ff @(posedge clk) begin
        if (rst) rdy_sync <= 2'b11;
        else     rdy_sync <= {rdy_sync[0], mem_rdy};
    end
    assign rdy_s = rdy_sync[1];

    eepw_pace #(.BLC_CYC(BLC_CYC), .SETUP_CYC(SETUP_CYC)) u_pace (
        .clk    (clk),
        .rst    (rst),
        .clr    (st == S_LOW && tmr == T_W'(PULSE_CYC - 1)),
        .run    (st == S_HOLD || st == S_GAP || st == S_DRAIN),
        .late   (late),
        .drained(drained)
    );

    eepw_wdog #(.WD_CYC(WD_CYC)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .clr    (st == S_DRAIN),
        .run    (st == S_BSY_LO || st == S_BSY_HI),
        .expired(expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            wa     <= '0;
            left   <= '0;
            byte_q <= '0;
            tmr    <= '0;
            first  <= 1'b1;
            fin    <= 1'b0;
            done_q <= 1'b0;
            stat_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                S_IDLE: if (req_valid) begin
                    wa     <= req_addr;
                    left   <= req_cnt;
                    first  <= 1'b1;
                    fin    <= 1'b0;
                    stat_q <= '0;
                    st     <= S_GAP;
                end
                S_GAP: if (dat_valid) begin
                    byte_q <= dat_byte;
                    tmr    <= '0;
                    st     <= S_SETUP;
                end else if (!first && late) begin
                    // Deadline reached with no byte: close the page.
                    stat_q.short_page <= 1'b1;
                    fin               <= 1'b1;
                    st                <= S_DRAIN;
                end
                S_SETUP: if (tmr == T_W'(SETUP_CYC - 1)) begin
                    tmr <= '0;
                    st  <= S_LOW;
                end else tmr <= tmr + 1'b1;
                S_LOW: if (tmr == T_W'(PULSE_CYC - 1)) begin
                    tmr <= '0;
                    st  <= S_HOLD;
                end else tmr <= tmr + 1'b1;
                S_HOLD: if (tmr == T_W'(HOLD_CYC - 1)) begin
                    tmr    <= '0;
                    first  <= 1'b0;
                    wa.off <= wa.off + 1'b1;
                    if (left == '0) begin
                        fin <= 1'b1;
                        st  <= S_DRAIN;
                    end else begin
                        left <= left - 1'b1;
                        st   <= at_page_end(wa.off) ? S_DRAIN : S_GAP;
                    end
                end else tmr <= tmr + 1'b1;
                S_DRAIN: if (drained) st <= S_BSY_LO;
                S_BSY_LO: if (expired) begin
                    stat_q.timeout <= 1'b1;
                    done_q         <= 1'b1;
                    st             <= S_IDLE;
                end else if (!rdy_s) st <= S_BSY_HI;
                S_BSY_HI: if (expired) begin
                    stat_q.timeout <= 1'b1;
                    done_q         <= 1'b1;
                    st             <= S_IDLE;
                end else if (rdy_s) begin
                    if (fin) begin
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                    end else begin
                        wa.page <= wa.page + 1'b1;
                        first   <= 1'b1;
                        st      <= S_GAP;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready    = (st == S_IDLE);
    assign dat_ready    = (st == S_GAP);
    assign mem_ce_n     = !(st == S_SETUP || st == S_LOW || st == S_HOLD);
    assign mem_we_n     = (st != S_LOW);
    assign mem_oe_n     = 1'b1;
    assign mem_dq_oe    = !mem_ce_n;
    assign mem_addr     = wa;
    assign mem_dq_o     = byte_q;
    assign done         = done_q;
    assign done_short   = done_q & stat_q.short_page;
    assign done_timeout = done_q & stat_q.timeout;

    // Independent observer of write-enable high time within a page.
    logic [H_W-1:0] we_hi_cnt;
    logic           page_open;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_hi_cnt <= '0;
            page_open <= 1'b0;
        end else begin
            if (!mem_we_n) we_hi_cnt <= '0;
            else if (we_hi_cnt != H_W'(BLC_CYC + 1)) we_hi_cnt <= we_hi_cnt + 1'b1;
            if (st == S_LOW)        page_open <= 1'b1;
            else if (st == S_DRAIN) page_open <= 1'b0;
        end
    end

    p_we_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);

    p_bus_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    p_byte_pace_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_we_n) && page_open) |-> (we_hi_cnt <= H_W'(BLC_CYC)));

    p_drain_len_r5: assert property (@(posedge clk) disable iff (rst)
        (st == S_BSY_LO && $past(st) == S_DRAIN) |-> (we_hi_cnt >= H_W'(BLC_CYC)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_tmo_flag_r8: assert property (@(posedge clk) disable iff (rst)
        done_timeout |-> (done && $past(st == S_BSY_LO || st == S_BSY_HI)));
endmodule

// File: tb/eeprom_pgwr_ctrl_tb.sv
module eeprom_pgwr_ctrl_tb;
    localparam int SETUP = 2, PULSE = 3, HOLD = 2, BLC = 12, WD = 200;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, dat_valid = 1'b0;
    logic [12:0] req_addr = '0;
    logic [4:0]  req_cnt = '0;
    logic [7:0]  dat_byte = '0;
    logic        req_ready, dat_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [12:0] mem_addr;
    logic [7:0]  mem_dq_o;
    logic        rdy_drv = 1'b1;
    logic        done, done_short, done_timeout;

    always #5 clk = ~clk;

    eeprom_pgwr_ctrl #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
                       .BLC_CYC(BLC), .WD_CYC(WD)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_cnt(req_cnt),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_rdy(rdy_drv), .done(done), .done_short(done_short), .done_timeout(done_timeout)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Device model: captures bytes, measures strobe timing, emulates busy.
    int          cap_n = 0, n_busy = 0, busy_len = 30, max_gap = 0;
    logic [12:0] cap_addr [0:63];
    logic [7:0]  cap_data [0:63];
    bit          prev_we = 1, prev_ce_low = 0, pend = 0;
    int          hi = 0, lo = 0, stab = 0, hold_left = 0, bleft = 0;
    logic [12:0] p_addr = '0, h_addr = '0;
    logic [7:0]  p_dq = '0, h_dq = '0;

    always @(negedge clk) begin
        if (rst) begin
            prev_we = 1; prev_ce_low = 0; pend = 0; hi = 0; lo = 0; stab = 0;
            hold_left = 0; bleft = 0; rdy_drv = 1'b1;
        end else begin
            if (!mem_ce_n) begin
                if (prev_ce_low && mem_addr == p_addr && mem_dq_o == p_dq) stab++;
                else stab = 1;
            end else stab = 0;
            if (prev_we && !mem_we_n) begin
                if (pend) begin
                    chk(hi <= BLC, "R4 byte-load interval", hi, BLC);
                    if (hi > max_gap) max_gap = hi;
                end
                chk(stab >= SETUP + 1, "R3 setup window", stab, SETUP + 1);
                chk(mem_oe_n == 1'b1, "R3 output-enable high", mem_oe_n, 1);
                chk(rdy_drv == 1'b1, "R7 no write while busy", rdy_drv, 1);
                lo = 1;
            end else if (!mem_we_n) lo++;
            if (!prev_we && mem_we_n) begin
                chk(lo == PULSE, "R3 pulse width", lo, PULSE);
                chk(!mem_ce_n && mem_dq_oe, "R3 hold at rise", mem_ce_n, 0);
                if (cap_n < 64) begin
                    cap_addr[cap_n] = mem_addr;
                    cap_data[cap_n] = mem_dq_o;
                end
                cap_n++;
                pend = 1; hi = 1; hold_left = HOLD - 1;
                h_addr = mem_addr; h_dq = mem_dq_o;
            end else if (mem_we_n) begin
                if (hi < 100000) hi++;
                if (hold_left > 0) begin
                    chk(!mem_ce_n && mem_addr == h_addr && mem_dq_o == h_dq,
                        "R3 hold window", mem_addr, h_addr);
                    hold_left--;
                end
            end
            if (pend && mem_we_n && hi > BLC) begin
                pend = 0; rdy_drv = 1'b0; bleft = busy_len; n_busy++;
            end else if (!rdy_drv) begin
                if (bleft > 0) bleft--;
                else rdy_drv = 1'b1;
            end
            prev_we = mem_we_n;
            prev_ce_low = !mem_ce_n;
            p_addr = mem_addr;
            p_dq = mem_dq_o;
        end
    end

    int dly [0:31];
    int seed = 0;

    function automatic logic [7:0] dgen(input int k);
        return 8'(k * 29 + 7);
    endfunction

    task automatic send_byte(input logic [7:0] d, input int delay, output bit ok);
        int  cnt;
        bit  seen;
        cnt = 0; seen = 0; ok = 0;
        forever begin
            @(negedge clk);
            if (dat_ready) begin
                seen = 1;
                if (cnt == delay) begin
                    dat_valid = 1'b1; dat_byte = d;
                    @(negedge clk);
                    dat_valid = 1'b0;
                    ok = 1;
                    return;
                end
                cnt++;
            end else if (seen) begin
                return;
            end
        end
    endtask

    task automatic do_page(input logic [12:0] a, input int n,
                           output bit sh, output bit tm, output int sent);
        cap_n = 0; n_busy = 0; max_gap = 0; sent = 0; sh = 0; tm = 0;
        fork
            begin
                @(negedge clk);
                req_valid = 1'b1; req_addr = a; req_cnt = 5'(n - 1);
                @(negedge clk);
                req_valid = 1'b0;
            end
            begin
                bit ok;
                for (int i = 0; i < n; i++) begin
                    send_byte(dgen(i + seed), dly[i], ok);
                    if (!ok) break;
                    sent++;
                end
            end
            begin
                forever begin
                    @(negedge clk);
                    if (done) begin
                        sh = done_short; tm = done_timeout;
                        break;
                    end
                end
            end
        join
    endtask

    task automatic check_bytes(input logic [12:0] a, input int n, input string tag);
        chk(cap_n == n, {tag, " byte count"}, cap_n, n);
        for (int i = 0; i < n && i < cap_n; i++) begin
            chk(cap_addr[i] == a + 13'(i), {tag, " address"}, cap_addr[i], a + 13'(i));
            chk(cap_data[i] == dgen(i + seed), {tag, " data"}, cap_data[i], dgen(i + seed));
        end
    endtask

    task automatic t_reset();
        chk(mem_we_n && mem_ce_n && mem_oe_n, "R9 strobes high after reset", mem_we_n, 1);
        chk(done == 1'b0, "R9 done low after reset", done, 0);
        chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
        chk(dat_ready == 1'b0, "R1 no byte taken when idle", dat_ready, 0);
    endtask

    task automatic t_basic();
        bit sh, tm; int s;
        for (int i = 0; i < 32; i++) dly[i] = 0;
        seed = 3;
        do_page(13'h0A43, 4, sh, tm, s);
        check_bytes(13'h0A43, 4, "R2 basic");
        chk(!sh && !tm, "R9 basic status clean", {sh, tm}, 0);
        chk(n_busy == 1, "R5 one busy phase", n_busy, 1);
        chk(req_ready == 1'b1, "R1 idle after done", req_ready, 1);
    endtask

    task automatic t_full_page();
        bit sh, tm; int s;
        for (int i = 0; i < 32; i++) dly[i] = i % 3;
        seed = 40;
        do_page(13'h1FE0, 32, sh, tm, s);
        check_bytes(13'h1FE0, 32, "R2 full page");
        chk(n_busy == 1 && !sh, "R5 full page single program", n_busy, 1);
    endtask

    task automatic t_split();
        bit sh, tm; int s;
        for (int i = 0; i < 32; i++) dly[i] = 0;
        seed = 77;
        do_page(13'h013E, 4, sh, tm, s);
        check_bytes(13'h013E, 4, "R7 split");
        chk(n_busy == 2, "R7 two busy phases", n_busy, 2);
        chk(!sh && !tm, "R7 split status clean", {sh, tm}, 0);
    endtask

    task automatic t_deadline();
        bit sh, tm; int s;
        for (int i = 0; i < 32; i++) dly[i] = 7;
        dly[0] = 0;
        seed = 11;
        do_page(13'h0808, 3, sh, tm, s);
        check_bytes(13'h0808, 3, "R6 last-cycle byte");
        chk(!sh, "R6 no short on last legal cycle", sh, 0);
        chk(max_gap == BLC, "R4 gap equals limit", max_gap, BLC);
    endtask

    task automatic t_late();
        bit sh, tm; int s;
        for (int i = 0; i < 32; i++) dly[i] = 0;
        dly[1] = 8;
        seed = 19;
        do_page(13'h0808, 3, sh, tm, s);
        check_bytes(13'h0808, 1, "R6 late byte");
        chk(sh == 1'b1, "R6 short flagged", sh, 1);
        chk(s == 1, "R6 late byte not taken", s, 1);
        chk(n_busy == 1, "R5 short page still programmed", n_busy, 1);
    endtask

    task automatic t_timeout();
        bit sh, tm; int s;
        for (int i = 0; i < 32; i++) dly[i] = 0;
        seed = 5;
        busy_len = 100000;
        do_page(13'h0100, 2, sh, tm, s);
        chk(tm == 1'b1, "R8 timeout flagged", tm, 1);
        chk(rdy_drv == 1'b0, "R8 device still busy at timeout", rdy_drv, 0);
        busy_len = 30;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && mem_we_n, "R9 recovers after reset", req_ready, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_full_page();
        t_split();
        t_deadline();
        t_late();
        t_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule